// File: doc/BRIEF.md
# Single-Word Floating Adder with Normalize and Round

This unit adds or subtracts two 36-bit floating words and returns one normalized 36-bit word. A word holds a sign in bit 35, an exponent in bits 34:27 stored with a bias of 128, and a 27-bit fraction in bits 26:0. A negative value is the twos complement of the whole positive word. The operand with the smaller exponent is shifted right inside a double-length signed register. The two terms are summed there. The sum is then normalized and, when `rnd_en` is set, rounded away from zero to a single word. Finally its exponent is checked against the representable range.

Operands enter on a valid/ready stream: a request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and presented on `out_valid`/`out_word` one cycle later, together with any flag update. It stays stable while `out_ready` is low. Under back-pressure `in_ready` drops, so nothing is accepted until the held result is taken. A result and a new request may change hands on the same edge. The four range flags are plain outputs that only ever get set. They are cleared only by reset, so software must clear them by other means.

Top module: `fp_addsub_unit`

## Requirements
- R1: The sum of two normalized operands is returned normalized: fraction bit 26 of its magnitude is 1. A carry out of the fraction shifts the sum right once and raises the exponent by 1 (0.5 + 0.5 gives exponent field 129, fraction 0x4000000).
- R2: With `op_sub` high, the result is `op_a` plus the twos complement of `op_b`.
- R3: The smaller-exponent term is arithmetically shifted right by the exponent difference in a register with 54 fraction bits. For a difference of 54 to 72 it therefore becomes all sign bits: 0 if positive, minus one double-length LSB if negative. For a difference above 72 it is replaced by zero.
- R4: A zero double-length sum yields the all-zero word and no flag change. A nonzero sum after cancellation is shifted left with zeros entering at the right, and the exponent drops by one per shift.
- R5: Words use sign bit 35, a biased-128 exponent in bits 34:27 and a fraction in bits 26:0. A negative result is the twos complement of the whole positive word.
- R6: With `rnd_en` high, the retained 27-bit magnitude is increased by one LSB when the dropped bits are at least half an LSB (the first dropped bit is 1). This makes rounding away from zero for either sign. With `rnd_en` low the dropped bits are discarded.
- R7: If rounding carries out of the fraction, the fraction is shifted right once more and the exponent raised by 1.
- R8: A final exponent above 127 sets `trap_flag`, `ovf_flag` and `fovf_flag`, and the stored exponent is 256 lower. A final exponent below -128 sets those three and also `funf_flag`, and the stored exponent is 256 higher.
- R9: Flags are sticky: they are set only in the cycle a result is loaded and are never cleared except by reset.
- R10: While `out_valid` is high and `out_ready` is low, `out_word` holds and `in_ready` is low. Otherwise `in_ready` is high.
- R11: After reset `out_valid` is 0, `in_ready` is 1 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| op_a | input | 36 | Augend / minuend word |
| op_b | input | 36 | Addend / subtrahend word |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| rnd_en | input | 1 | 1 = round the result word |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 36 | Result word |
| trap_flag | output | 1 | Sticky trap request |
| ovf_flag | output | 1 | Sticky overflow |
| fovf_flag | output | 1 | Sticky floating overflow |
| funf_flag | output | 1 | Sticky floating underflow |

## Verification
The normalization assertion takes for granted that both operands are normalized or zero. It also assumes no operand has a zero fraction with a nonzero exponent and no negative word has a fraction of -1, because malformed words may yield unnormalized sums. Every vector in the stimulus table is built from such well-formed words, including the wide-gap, rounding-carry and range-wrap cases. The hold assertion assumes the consumer may stall for any number of cycles; the bench stalls for several while offering a second request.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 27;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SUM_W  = 2 * FRAC_W + 2;
  localparam int BIAS   = 1 << (EXP_W - 1);

  typedef struct packed {
    logic trap;
    logic ovf;
    logic fovf;
    logic funf;
  } fp_flags_t;
endpackage

// File: rtl/fp_align_add.sv
module fp_align_add #(
  parameter int EW     = 8,
  parameter int FW     = 27,
  parameter int ZLIMIT = 72,
  localparam int WW    = 1 + EW + FW,
  localparam int SW    = 2 * FW + 2
) (
  input  logic [WW-1:0]        a_word,
  input  logic [WW-1:0]        b_word,
  input  logic                 sub,
  output logic signed [SW-1:0] sum,
  output logic [EW-1:0]        exp_big
);
  logic [WW-1:0]        b_eff;
  logic [EW-1:0]        ea, eb;
  logic signed [FW:0]   fa, fb;
  logic signed [SW-1:0] xa, xb, big_x, small_x, small_sh;
  logic [EW:0]          diff;

  always_comb begin
    b_eff = sub ? (~b_word + WW'(1)) : b_word;
    ea = a_word[WW-1] ? ~a_word[WW-2:FW] : a_word[WW-2:FW];
    eb = b_eff[WW-1]  ? ~b_eff[WW-2:FW]  : b_eff[WW-2:FW];
    fa = {a_word[WW-1], a_word[FW-1:0]};
    fb = {b_eff[WW-1],  b_eff[FW-1:0]};
    xa = {{(SW-FW-1){fa[FW]}}, fa} <<< FW;
    xb = {{(SW-FW-1){fb[FW]}}, fb} <<< FW;
    if (ea >= eb) begin
      big_x = xa; small_x = xb; exp_big = ea;
      diff = {1'b0, ea} - {1'b0, eb};
    end else begin
      big_x = xb; small_x = xa; exp_big = eb;
      diff = {1'b0, eb} - {1'b0, ea};
    end
    if (int'(diff) > ZLIMIT) small_sh = '0;
    else                     small_sh = small_x >>> diff;
    sum = big_x + small_sh;
  end
endmodule

// File: rtl/fp_norm_round.sv
module fp_norm_round #(
  parameter int EW  = 8,
  parameter int FW  = 27,
  localparam int WW = 1 + EW + FW,
  localparam int SW = 2 * FW + 2,
  localparam int TOP = 2 * FW - 1,
  localparam int BIAS = 1 << (EW - 1)
) (
  input  logic signed [SW-1:0] sum,
  input  logic [EW-1:0]        exp_big,
  input  logic                 rnd,
  output logic [WW-1:0]        word,
  output logic                 rng_ovf,
  output logic                 rng_unf
);
  logic          neg;
  logic [SW-1:0] mag, nrm;
  int            pos, e_fin;
  logic [FW:0]   rsum;
  logic [FW-1:0] frac;
  logic [EW-1:0] fld;
  logic [WW-1:0] pword;

  function automatic int lead_one(input logic [SW-1:0] v);
    int p = 0;
    for (int i = 0; i < SW; i++) if (v[i]) p = i;
    return p;
  endfunction

  always_comb begin
    neg = sum[SW-1];
    mag = neg ? SW'(-sum) : SW'(sum);
    pos = lead_one(mag);
    if (pos > TOP) nrm = mag >> (pos - TOP);
    else           nrm = mag << (TOP - pos);
    e_fin = int'(exp_big) - BIAS + pos - TOP;
    rsum = {1'b0, nrm[TOP:FW]} + (FW+1)'(rnd & nrm[FW-1]);
    if (rsum[FW]) begin
      frac  = rsum[FW:1];
      e_fin = e_fin + 1;
    end else begin
      frac = rsum[FW-1:0];
    end
    fld   = EW'(e_fin + BIAS);
    pword = {1'b0, fld, frac};
    if (mag == '0) begin
      word = '0; rng_ovf = 1'b0; rng_unf = 1'b0;
    end else begin
      word    = neg ? (~pword + WW'(1)) : pword;
      rng_unf = (e_fin < -BIAS);
      rng_ovf = (e_fin > BIAS - 1) || rng_unf;
    end
  end
endmodule

// File: rtl/fp_addsub_unit.sv
module fp_addsub_unit
  import fp_addsub_pkg::*;
#(
  parameter int ZLIMIT = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_sub,
  input  logic              rnd_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              trap_flag,
  output logic              ovf_flag,
  output logic              fovf_flag,
  output logic              funf_flag
);
  logic signed [SUM_W-1:0] sum;
  logic [EXP_W-1:0]        exp_big;
  logic [WORD_W-1:0]       res_word;
  logic                    rng_ovf, rng_unf, fire;
  fp_flags_t               flg;

  fp_align_add #(.EW(EXP_W), .FW(FRAC_W), .ZLIMIT(ZLIMIT)) u_align (
    .a_word(op_a), .b_word(op_b), .sub(op_sub), .sum(sum), .exp_big(exp_big)
  );

  fp_norm_round #(.EW(EXP_W), .FW(FRAC_W)) u_norm (
    .sum(sum), .exp_big(exp_big), .rnd(rnd_en),
    .word(res_word), .rng_ovf(rng_ovf), .rng_unf(rng_unf)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      flg       <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_word  <= res_word;
        flg.trap  <= flg.trap | rng_ovf;
        flg.ovf   <= flg.ovf  | rng_ovf;
        flg.fovf  <= flg.fovf | rng_ovf;
        flg.funf  <= flg.funf | rng_unf;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign trap_flag = flg.trap;
  assign ovf_flag  = flg.ovf;
  assign fovf_flag = flg.fovf;
  assign funf_flag = flg.funf;

  logic [WORD_W-1:0] out_mag;
  assign out_mag = out_word[WORD_W-1] ? (~out_word + WORD_W'(1)) : out_word;

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flag || ovf_flag || fovf_flag || funf_flag |=>
      ($past(trap_flag) -> trap_flag) && ($past(ovf_flag) -> ovf_flag) &&
      ($past(fovf_flag) -> fovf_flag) && ($past(funf_flag) -> funf_flag));
  a_r9_set_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_flag) |-> $past(fire));
  a_r8_underflow_implies_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    funf_flag |-> trap_flag && ovf_flag && fovf_flag);
  a_r1_result_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word != '0 |-> out_mag[FRAC_W-1]);
endmodule

// File: tb/fp_addsub_unit_tb_top.sv
module fp_addsub_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [35:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0, rnd_en = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [35:0] out_word;
  logic        trap_flag, ovf_flag, fovf_flag, funf_flag;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  fp_addsub_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .rnd_en(rnd_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .trap_flag(trap_flag), .ovf_flag(ovf_flag), .fovf_flag(fovf_flag),
    .funf_flag(funf_flag)
  );

  // R5 word encoding: sign 35, biased exponent 34:27, fraction 26:0, negative = twos complement
  function automatic logic [35:0] mk(input logic s, input logic [7:0] e, input logic [26:0] f);
    logic [35:0] w = {1'b0, e, f};
    return s ? (~w + 36'd1) : w;
  endfunction

  // fields: a(s,e,f) b(s,e,f) sub rnd expected(s,e,f) flags{trap,ovf,fovf,funf}
  localparam int NV = 16;
  localparam logic [113:0] VEC [NV] = '{
    {1'b0,8'd128,27'h4000000, 1'b0,8'd128,27'h4000000, 1'b0,1'b0, 1'b0,8'd129,27'h4000000, 4'b0000}, // R1 carry out
    {1'b0,8'd128,27'h4000000, 1'b0,8'd128,27'h4000000, 1'b1,1'b0, 1'b0,8'd0,  27'h0000000, 4'b0000}, // R4 zero
    {1'b0,8'd128,27'h6000000, 1'b1,8'd128,27'h4000000, 1'b0,1'b0, 1'b0,8'd127,27'h4000000, 4'b0000}, // R5 negative operand
    {1'b0,8'd128,27'h6000000, 1'b0,8'd128,27'h4000000, 1'b1,1'b0, 1'b0,8'd127,27'h4000000, 4'b0000}, // R2 subtract
    {1'b0,8'd128,27'h4000000, 1'b0,8'd101,27'h4000000, 1'b0,1'b1, 1'b0,8'd128,27'h4000001, 4'b0000}, // R6 half LSB rounds up
    {1'b0,8'd128,27'h4000000, 1'b0,8'd101,27'h4000000, 1'b0,1'b0, 1'b0,8'd128,27'h4000000, 4'b0000}, // R6 truncate
    {1'b0,8'd128,27'h7FFFFFF, 1'b0,8'd101,27'h4000000, 1'b0,1'b1, 1'b0,8'd129,27'h4000000, 4'b0000}, // R7 renormalize
    {1'b0,8'd200,27'h4000000, 1'b1,8'd127,27'h4000000, 1'b0,1'b0, 1'b0,8'd200,27'h4000000, 4'b0000}, // R3 gap 73 zeroed
    {1'b0,8'd200,27'h4000000, 1'b1,8'd128,27'h4000000, 1'b0,1'b0, 1'b0,8'd199,27'h7FFFFFF, 4'b0000}, // R3 gap 72 all ones
    {1'b0,8'd200,27'h4000000, 1'b1,8'd140,27'h4000000, 1'b0,1'b0, 1'b0,8'd199,27'h7FFFFFF, 4'b0000}, // R3 gap 60 negative
    {1'b0,8'd200,27'h4000000, 1'b0,8'd140,27'h4000000, 1'b0,1'b0, 1'b0,8'd200,27'h4000000, 4'b0000}, // R3 gap 60 positive
    {1'b1,8'd128,27'h4000000, 1'b1,8'd128,27'h4000000, 1'b0,1'b0, 1'b1,8'd129,27'h4000000, 4'b0000}, // R5 negative result
    {1'b1,8'd128,27'h4000000, 1'b1,8'd101,27'h4000000, 1'b0,1'b1, 1'b1,8'd128,27'h4000001, 4'b0000}, // R6 away from zero
    {1'b0,8'd128,27'h4000000, 1'b0,8'd101,27'h4000000, 1'b1,1'b1, 1'b0,8'd127,27'h7FFFFFF, 4'b0000}, // R4 left shift
    {1'b0,8'd255,27'h4000000, 1'b0,8'd255,27'h4000000, 1'b0,1'b0, 1'b0,8'd0,  27'h4000000, 4'b1110}, // R8 overflow wrap
    {1'b0,8'd0,  27'h6000000, 1'b0,8'd0,  27'h4000000, 1'b1,1'b0, 1'b0,8'd255,27'h4000000, 4'b1111}  // R8 underflow wrap
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [113:0] v);
    op_a = mk(v[113], v[112:105], v[104:78]);
    op_b = mk(v[77], v[76:69], v[68:42]);
    op_sub = v[41];
    rnd_en = v[40];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [35:0] flags4();
    return {32'd0, trap_flag, ovf_flag, fovf_flag, funf_flag};
  endfunction

  initial begin
    do_reset();
    // R11 reset state
    check("R11 out_valid", {35'd0, out_valid}, 36'd0);
    check("R11 in_ready", {35'd0, in_ready}, 36'd1);
    check("R11 flags", flags4(), 36'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      send(VEC[i]);
      check($sformatf("vec%0d R1/R2/R3/R4/R5/R6/R7 word", i), out_word,
            mk(VEC[i][39], VEC[i][38:31], VEC[i][30:4]));
      check($sformatf("vec%0d R8 flags", i), flags4(), {32'd0, VEC[i][3:0]});
      check($sformatf("vec%0d R10 out_valid", i), {35'd0, out_valid}, 36'd1);
    end

    // R9 sticky: overflow, then an in-range add with no reset
    do_reset();
    send(VEC[14]);
    @(negedge clk);
    send(VEC[0]);
    check("R9 word after overflow", out_word, mk(1'b0, 8'd129, 27'h4000000));
    check("R9 flags stay set", flags4(), 36'd14);
    repeat (3) @(negedge clk);
    check("R9 flags still set", flags4(), 36'd14);

    // R10 back-pressure
    do_reset();
    out_ready = 1'b0;
    send(VEC[0]);
    check("R10 in_ready low while held", {35'd0, in_ready}, 36'd0);
    op_a = mk(1'b1, 8'd128, 27'h4000000);
    op_b = mk(1'b1, 8'd128, 27'h4000000);
    op_sub = 1'b0; rnd_en = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 word held", out_word, mk(1'b0, 8'd129, 27'h4000000));
    check("R10 valid held", {35'd0, out_valid}, 36'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next result taken on release", out_word, mk(1'b1, 8'd129, 27'h4000000));
    @(negedge clk);
    check("R10 drained", {35'd0, out_valid}, 36'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule